// File: doc/BRIEF.md
# Rolling-Shutter Exposure Pointer Controller

This block sequences the rows of an image array that uses an electronic rolling shutter. A pixel-clock counter and a row counter together form the row period and the frame period. In each row period the block issues one read strobe and one reset strobe. The reset strobe is aimed at the row that will be read a set number of rows later, and that distance is the integration time counted in rows. When high-dynamic-range capture is on, a second reset strobe is placed in the middle of each row period. This second strobe starts a shorter exposure whose length is the long exposure divided by a selectable ratio.

The programmed integration value is clamped to the limits of the active mode. In linear mode, an integration that reaches the frame length stretches the frame with extra blank rows. In HDR mode, the limits come from a 70-row intermediate line buffer, so the frame is never stretched. Frame-valid and line-valid flags mark the rows and pixels of the visible image. All configuration inputs are sampled only at the frame boundary, so a value written in the middle of a frame first applies to the next frame.

Top module: `ers_pointer_ctrl`

## Requirements
- R1: While reset is high, every strobe and every flag output is low.
- R2: A row period lasts exactly `cfg_line_len` clocks. A frame period lasts the effective row count times that many clocks.
- R3: In linear mode the long exposure T1 equals `cfg_coarse`. A value of 0 is raised to 1 row.
- R4: In linear mode, when `cfg_coarse` is greater than or equal to `cfg_frame_len`, the frame lasts `cfg_coarse`+1 rows. Otherwise it lasts `cfg_frame_len` rows, so `cfg_frame_len`−1 is the largest exposure that does not stretch the frame.
- R5: In HDR mode the ratio code maps 0,1,2,3 to 4x,8x,16x,32x. T1 is clamped into the range [ratio/2, min(70·ratio, `cfg_frame_len`−71)], and the frame keeps `cfg_frame_len` rows.
- R6: In HDR mode the short exposure T2 is floor(T1/ratio), raised to 1 if that gives 0. T2 never exceeds 70 rows. Its reset strobe fires at pixel floor(`cfg_line_len`/2) of the row period, never together with a read strobe.
- R7: At pixel 0 of each row r that is below `ACT_ROWS`, `read_stb` pulses with `read_row`=r. The rows follow 0,1,2,… in order.
- R8: At pixel 0 of row r, `t1_rst_stb` pulses with `t1_rst_row`=(r+T1) mod frame rows, but only when that row is below `ACT_ROWS`. The T2 strobe uses the same rule with (r+T2).
- R9: `frame_valid` is high during rows below `ACT_ROWS`. `line_valid` is high only in those rows and only for pixels below `ACT_COLS`, so each frame has exactly `ACT_ROWS`·`ACT_COLS` line-valid cycles.
- R10: A configuration change made during a frame has no effect on that frame. It applies from the next frame.
- R11: In linear mode `t2_rst_stb` never fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset; the configuration is captured while it is high |
| cfg_line_len | input | PIX_W | Clocks per row period (at least 2) |
| cfg_frame_len | input | ROW_W | Rows per frame before any stretching |
| cfg_coarse | input | ROW_W | Requested long exposure in rows |
| cfg_hdr_en | input | 1 | 1 selects dual-exposure HDR mode |
| cfg_ratio | input | 2 | Ratio code for T1/T2: 0=4x, 1=8x, 2=16x, 3=32x |
| frame_valid | output | 1 | High during visible rows |
| line_valid | output | 1 | High on visible pixels of visible rows |
| read_stb | output | 1 | Row read pulse |
| read_row | output | ROW_W | Row being read |
| t1_rst_stb | output | 1 | Long-exposure reset pulse |
| t1_rst_row | output | ROW_W | Row being reset for the long exposure |
| t2_rst_stb | output | 1 | Short-exposure reset pulse (HDR only) |
| t2_rst_row | output | ROW_W | Row being reset for the short exposure |

## Verification
The bench builds the block with `ACT_ROWS`=8 and `ACT_COLS`=6 and keeps the 70-row buffer depth. This shrinks frames to 12–400 rows of 7–10 clocks, so several full frames run in a few thousand cycles. With these sizes, both HDR upper limits can be reached: the frame-length bound at 90 rows and the 70·ratio bound at 400 rows. So can the ratio/2 floor at 32x and linear stretching, both at the exact frame length and above it. Every new configuration is applied in the middle of a frame, so each frame's strobe sequence and period also test that changes wait for the next frame.

// File: rtl/ers_pkg.sv
package ers_pkg;
  localparam int HDR_BUF_ROWS = 70;

  // Ratio code to log2 of the T1/T2 ratio: 0..3 -> 2..5
  function automatic logic [2:0] ratio_shift(input logic [1:0] code);
    return {1'b0, code} + 3'd2;
  endfunction
endpackage

// File: rtl/ers_limit.sv
module ers_limit
  import ers_pkg::*;
#(
  parameter int ROW_W   = 12,
  parameter int HDR_BUF = HDR_BUF_ROWS
) (
  input  logic [ROW_W-1:0] frame_len,
  input  logic [ROW_W-1:0] coarse,
  input  logic             hdr_en,
  input  logic [1:0]       ratio_code,
  output logic [ROW_W-1:0] t1,
  output logic [ROW_W-1:0] t2,
  output logic [ROW_W-1:0] frame_rows
);
  localparam int EW = ROW_W + 7;
  localparam logic [EW-1:0] BUF_E   = EW'(HDR_BUF);
  localparam logic [EW-1:0] BUF_P1  = EW'(HDR_BUF + 1);
  localparam logic [EW-1:0] LIN_MAX = EW'((1 << ROW_W) - 2);
  localparam logic [EW-1:0] ONE     = EW'(1);

  logic [2:0]    sh;
  logic [EW-1:0] fl_e, co_e, cap_r, cap_f, hi, lo, v, s;

  always_comb begin
    sh    = ratio_shift(ratio_code);
    fl_e  = EW'(frame_len);
    co_e  = EW'(coarse);
    cap_r = BUF_E << sh;                       // line-buffer bound
    cap_f = (fl_e > BUF_P1) ? fl_e - BUF_P1 : '0; // frame-length bound
    hi    = (cap_r < cap_f) ? cap_r : cap_f;
    lo    = ONE << (sh - 3'd1);                // ratio / 2
    if (hdr_en) begin
      v = co_e;
      if (v > hi) v = hi;
      if (v < lo) v = lo;
      s = v >> sh;
      if (s == '0) s = ONE;
      t1         = ROW_W'(v);
      t2         = ROW_W'(s);
      frame_rows = frame_len;
    end else begin
      v = (co_e == '0) ? ONE : co_e;
      if (v > LIN_MAX) v = LIN_MAX;
      s          = '0;
      t1         = ROW_W'(v);
      t2         = ROW_W'(s);
      frame_rows = (v >= fl_e) ? ROW_W'(v + ONE) : frame_len;
    end
  end
endmodule

// File: rtl/ers_timebase.sv
module ers_timebase #(
  parameter int PIX_W = 16,
  parameter int ROW_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] line_len,
  input  logic [ROW_W-1:0] frame_rows,
  output logic [PIX_W-1:0] pcnt,
  output logic [ROW_W-1:0] rcnt,
  output logic             frame_last
);
  logic row_last;

  assign row_last   = (pcnt == line_len - PIX_W'(1));
  assign frame_last = row_last && (rcnt == frame_rows - ROW_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt <= '0;
      rcnt <= '0;
    end else if (row_last) begin
      pcnt <= '0;
      rcnt <= frame_last ? '0 : rcnt + ROW_W'(1);
    end else begin
      pcnt <= pcnt + PIX_W'(1);
    end
  end

  AST_PCNT_IN_ROW: assert property (@(posedge clk) disable iff (rst)
    (line_len >= PIX_W'(2)) |-> (pcnt < line_len)); // R2
  AST_RCNT_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    (frame_rows != '0) |-> (rcnt < frame_rows)); // R4
endmodule

// File: rtl/ers_ptrgen.sv
module ers_ptrgen
  import ers_pkg::*;
#(
  parameter int PIX_W    = 16,
  parameter int ROW_W    = 12,
  parameter int ACT_ROWS = 1536,
  parameter int ACT_COLS = 2048,
  parameter int HDR_BUF  = HDR_BUF_ROWS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] pcnt,
  input  logic [ROW_W-1:0] rcnt,
  input  logic [PIX_W-1:0] line_len,
  input  logic [ROW_W-1:0] frame_rows,
  input  logic [ROW_W-1:0] t1,
  input  logic [ROW_W-1:0] t2,
  input  logic             hdr,
  output logic             frame_valid,
  output logic             line_valid,
  output logic             read_stb,
  output logic [ROW_W-1:0] read_row,
  output logic             t1_stb,
  output logic [ROW_W-1:0] t1_row,
  output logic             t2_stb,
  output logic [ROW_W-1:0] t2_row
);
  localparam logic [ROW_W:0] ACT_R = (ROW_W+1)'(ACT_ROWS);
  localparam logic [PIX_W:0] ACT_C = (PIX_W+1)'(ACT_COLS);

  logic [ROW_W:0] s1, s2, fr_e;
  logic           row_vis, at_start, at_half;

  always_comb begin
    fr_e = {1'b0, frame_rows};
    s1   = {1'b0, rcnt} + {1'b0, t1};
    if (s1 >= fr_e) s1 = s1 - fr_e;
    s2   = {1'b0, rcnt} + {1'b0, t2};
    if (s2 >= fr_e) s2 = s2 - fr_e;
    row_vis  = {1'b0, rcnt} < ACT_R;
    at_start = (pcnt == '0);
    at_half  = (pcnt == (line_len >> 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_valid <= 1'b0;
      line_valid  <= 1'b0;
      read_stb    <= 1'b0;
      read_row    <= '0;
      t1_stb      <= 1'b0;
      t1_row      <= '0;
      t2_stb      <= 1'b0;
      t2_row      <= '0;
    end else begin
      frame_valid <= row_vis;
      line_valid  <= row_vis && ({1'b0, pcnt} < ACT_C);
      read_stb    <= row_vis && at_start;
      read_row    <= rcnt;
      t1_stb      <= at_start && (s1 < ACT_R);
      t1_row      <= s1[ROW_W-1:0];
      t2_stb      <= hdr && at_half && (s2 < ACT_R);
      t2_row      <= s2[ROW_W-1:0];
    end
  end

  // Checker state: previous read row
  logic [ROW_W-1:0] last_rd;
  always_ff @(posedge clk) begin
    if (rst) last_rd <= '0;
    else if (read_stb) last_rd <= read_row;
  end

  AST_LV_IN_FV: assert property (@(posedge clk) disable iff (rst)
    line_valid |-> frame_valid); // R9
  AST_RD_SEQ: assert property (@(posedge clk) disable iff (rst)
    (read_stb && read_row != '0) |-> (read_row == last_rd + ROW_W'(1))); // R7
  AST_T2_APART: assert property (@(posedge clk) disable iff (rst)
    t2_stb |-> !read_stb); // R6
  AST_T2_HDR_ONLY: assert property (@(posedge clk) disable iff (rst)
    t2_stb |-> $past(hdr)); // R11
  AST_T2_CAP: assert property (@(posedge clk) disable iff (rst)
    hdr |-> (t2 >= ROW_W'(1) && t2 <= ROW_W'(HDR_BUF))); // R6
  AST_T1_MIN: assert property (@(posedge clk) disable iff (rst)
    t1 >= ROW_W'(1)); // R3
endmodule

// File: rtl/ers_pointer_ctrl.sv
module ers_pointer_ctrl
  import ers_pkg::*;
#(
  parameter int PIX_W    = 16,
  parameter int ROW_W    = 12,
  parameter int ACT_ROWS = 1536,
  parameter int ACT_COLS = 2048,
  parameter int HDR_BUF  = HDR_BUF_ROWS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] cfg_line_len,
  input  logic [ROW_W-1:0] cfg_frame_len,
  input  logic [ROW_W-1:0] cfg_coarse,
  input  logic             cfg_hdr_en,
  input  logic [1:0]       cfg_ratio,
  output logic             frame_valid,
  output logic             line_valid,
  output logic             read_stb,
  output logic [ROW_W-1:0] read_row,
  output logic             t1_rst_stb,
  output logic [ROW_W-1:0] t1_rst_row,
  output logic             t2_rst_stb,
  output logic [ROW_W-1:0] t2_rst_row
);
  logic [ROW_W-1:0] lim_t1, lim_t2, lim_rows;
  logic [PIX_W-1:0] ll_q;
  logic [ROW_W-1:0] rows_q, t1_q, t2_q;
  logic             hdr_q;
  logic [PIX_W-1:0] pcnt;
  logic [ROW_W-1:0] rcnt;
  logic             frame_last;

  ers_limit #(.ROW_W(ROW_W), .HDR_BUF(HDR_BUF)) u_limit (
    .frame_len (cfg_frame_len),
    .coarse    (cfg_coarse),
    .hdr_en    (cfg_hdr_en),
    .ratio_code(cfg_ratio),
    .t1        (lim_t1),
    .t2        (lim_t2),
    .frame_rows(lim_rows)
  );

  // Frame-boundary shadow of the configuration
  always_ff @(posedge clk) begin
    if (rst || frame_last) begin
      ll_q   <= cfg_line_len;
      rows_q <= lim_rows;
      t1_q   <= lim_t1;
      t2_q   <= lim_t2;
      hdr_q  <= cfg_hdr_en;
    end
  end

  ers_timebase #(.PIX_W(PIX_W), .ROW_W(ROW_W)) u_tb (
    .clk       (clk),
    .rst       (rst),
    .line_len  (ll_q),
    .frame_rows(rows_q),
    .pcnt      (pcnt),
    .rcnt      (rcnt),
    .frame_last(frame_last)
  );

  ers_ptrgen #(
    .PIX_W(PIX_W), .ROW_W(ROW_W), .ACT_ROWS(ACT_ROWS),
    .ACT_COLS(ACT_COLS), .HDR_BUF(HDR_BUF)
  ) u_ptr (
    .clk        (clk),
    .rst        (rst),
    .pcnt       (pcnt),
    .rcnt       (rcnt),
    .line_len   (ll_q),
    .frame_rows (rows_q),
    .t1         (t1_q),
    .t2         (t2_q),
    .hdr        (hdr_q),
    .frame_valid(frame_valid),
    .line_valid (line_valid),
    .read_stb   (read_stb),
    .read_row   (read_row),
    .t1_stb     (t1_rst_stb),
    .t1_row     (t1_rst_row),
    .t2_stb     (t2_rst_stb),
    .t2_row     (t2_rst_row)
  );

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frame_last |=> ($stable(t1_q) && $stable(ll_q) && $stable(rows_q) && $stable(hdr_q))); // R10
endmodule

// File: tb/ers_pointer_ctrl_tb_top.sv
`timescale 1ns/1ps
module ers_pointer_ctrl_tb_top;
  localparam int PIX_W = 16;
  localparam int ROW_W = 12;
  localparam int AR    = 8;
  localparam int AC    = 6;
  localparam int HB    = 70;
  localparam int NCFG  = 9;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [PIX_W-1:0] cfg_line_len;
  logic [ROW_W-1:0] cfg_frame_len, cfg_coarse;
  logic             cfg_hdr_en;
  logic [1:0]       cfg_ratio;
  logic             frame_valid, line_valid, read_stb, t1_rst_stb, t2_rst_stb;
  logic [ROW_W-1:0] read_row, t1_rst_row, t2_rst_row;

  always #2.5 clk = ~clk;

  ers_pointer_ctrl #(
    .PIX_W(PIX_W), .ROW_W(ROW_W), .ACT_ROWS(AR), .ACT_COLS(AC), .HDR_BUF(HB)
  ) dut_i (
    .clk(clk), .rst(rst),
    .cfg_line_len(cfg_line_len), .cfg_frame_len(cfg_frame_len),
    .cfg_coarse(cfg_coarse), .cfg_hdr_en(cfg_hdr_en), .cfg_ratio(cfg_ratio),
    .frame_valid(frame_valid), .line_valid(line_valid),
    .read_stb(read_stb), .read_row(read_row),
    .t1_rst_stb(t1_rst_stb), .t1_rst_row(t1_rst_row),
    .t2_rst_stb(t2_rst_stb), .t2_rst_row(t2_rst_row)
  );

  // line_len, frame_len, coarse, hdr, ratio code
  int cfg_tab [NCFG][5] = '{
    '{10, 12,   5, 0, 0},  // R3 plain linear
    '{10, 12,   0, 0, 0},  // R3 zero raised to 1
    '{ 9, 12,  20, 0, 0},  // R4 stretched to 21 rows
    '{10, 12,  12, 0, 0},  // R4 equal -> 13 rows
    '{ 8, 90, 100, 1, 0},  // R5 frame bound: T1=19, T2=4
    '{ 8, 90,   5, 1, 3},  // R5 floor 16 at 32x, T2=1
    '{ 8, 400, 350, 1, 0}, // R5 buffer bound: T1=280, T2=70
    '{ 8, 100, 24, 1, 1},  // R5 in range: T1=24, T2=3
    '{ 7, 15,  14, 0, 0}   // R4 fl-1, no stretch
  };
  string tag_tab [NCFG] = '{"R3", "R3", "R4", "R4", "R5", "R5", "R5", "R5", "R4"};

  int    evq[$];
  int    perq[$];
  string tagq[$];
  int    vectors = 0, fails = 0;
  bit    started = 0, mon_done = 0, finished = 0;
  int    rises = 0, cyc = 0, last_rise = 0, lv_cnt = 0;
  bit    fv_prev = 0;

  task automatic fail(string req, string what, int act, int exp_v);
    fails++;
    $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
  endtask

  task automatic apply(int k);
    cfg_line_len  = PIX_W'(cfg_tab[k][0]);
    cfg_frame_len = ROW_W'(cfg_tab[k][1]);
    cfg_coarse    = ROW_W'(cfg_tab[k][2]);
    cfg_hdr_en    = cfg_tab[k][3][0];
    cfg_ratio     = 2'(cfg_tab[k][4]);
  endtask

  // Driver: push the expected strobe sequence and period of one frame
  task automatic expect_frame(int k);
    int ll = cfg_tab[k][0], fl = cfg_tab[k][1], co = cfg_tab[k][2];
    int hdr = cfg_tab[k][3], ratio = 1 << (cfg_tab[k][4] + 2);
    int t1, t2 = 0, frows, hi, lo;
    if (hdr != 0) begin
      hi = (fl > HB + 1) ? fl - HB - 1 : 0;
      if (HB * ratio < hi) hi = HB * ratio;
      lo = ratio / 2;
      t1 = co;
      if (t1 > hi) t1 = hi;
      if (t1 < lo) t1 = lo;
      t2 = t1 / ratio;
      if (t2 < 1) t2 = 1;
      frows = fl;
    end else begin
      t1 = (co < 1) ? 1 : co;
      frows = (t1 >= fl) ? t1 + 1 : fl;
    end
    for (int r = 0; r < frows; r++) begin
      if (r < AR) evq.push_back(r);
      if ((r + t1) % frows < AR) evq.push_back((1 << 16) | ((r + t1) % frows));
      if (hdr != 0 && (r + t2) % frows < AR) evq.push_back((2 << 16) | ((r + t2) % frows));
    end
    perq.push_back(frows * ll);
    tagq.push_back(tag_tab[k]);
  endtask

  task automatic chk_ev(int kind, int row);
    int e;
    string req;
    req = (kind == 0) ? "R7" : (kind == 1) ? "R8" : "R6";
    vectors++;
    if (evq.size() == 0) begin
      fail(req, "unexpected strobe kind", kind, -1);
    end else begin
      e = evq.pop_front();
      if (e != ((kind << 16) | row))
        fail(req, "strobe kind<<16|row", (kind << 16) | row, e);
    end
  endtask

  // Monitor
  always @(negedge clk) begin
    cyc++;
    if (started && !mon_done) begin
      if (frame_valid && !fv_prev) begin
        rises++;
        if (rises > 1) begin
          string t;
          t = tagq.pop_front();
          vectors++;
          if (perq.size() == 0) fail("R2", "period queue empty", cyc - last_rise, -1);
          else begin
            int p;
            p = perq.pop_front();
            if (cyc - last_rise != p) fail({"R2/", t}, "frame period", cyc - last_rise, p);
          end
          vectors++;
          if (lv_cnt != AR * AC) fail("R9", "line_valid cycles", lv_cnt, AR * AC);
        end
        last_rise = cyc;
        lv_cnt = 0;
        if (rises == NCFG + 1) mon_done = 1;
      end
      if (!mon_done) begin
        if (read_stb)   chk_ev(0, int'(read_row));
        if (t1_rst_stb) chk_ev(1, int'(t1_rst_row));
        if (t2_rst_stb) chk_ev(2, int'(t2_rst_row)); // R11: none expected in linear frames
        if (line_valid) lv_cnt++;
      end
    end
    fv_prev = frame_valid;
  end

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fail("R2", "watchdog expired, frames seen", rises, NCFG + 1);
      summary();
      $finish;
    end
  end

  initial begin
    apply(0);
    expect_frame(0);
    repeat (4) @(negedge clk);
    // R1: outputs idle in reset
    vectors++;
    if ({frame_valid, line_valid, read_stb, t1_rst_stb, t2_rst_stb} != 5'b0)
      fail("R1", "outputs during reset", int'({frame_valid, line_valid, read_stb, t1_rst_stb, t2_rst_stb}), 0);
    rst = 1'b0;
    started = 1;
    for (int k = 1; k < NCFG; k++) begin
      wait (rises >= k);
      repeat (3) @(negedge clk);
      apply(k);          // R10: mid-frame change, must wait for next frame
      expect_frame(k);
    end
    wait (mon_done);
    @(negedge clk);
    vectors++;
    if (evq.size() != 0) fail("R10", "strobes never produced", evq.size(), 0);
    vectors++;
    if (perq.size() != 0) fail("R2", "frames never closed", perq.size(), 0);
    if (!finished) begin
      finished = 1;
      summary();
      $finish;
    end
  end
endmodule